// File: doc/BRIEF.md
# Length-Prefixed Message Framer

This block sits behind a transport stage that has already removed the network headers. It receives the session payload as a stream of 64-bit beats and splits that stream into individual messages. Each payload starts with a fixed session header. After the header comes any number of messages. Each message is preceded by a two-byte length field. Messages are not aligned to beats, so one message may span several beats and one beat may hold several messages.

The framer collects the incoming bytes in a buffer with its front byte at position 0. It keeps a count of the bytes held and a register holding the size of the unit it is waiting for. The header is the first unit of every packet and is thrown away. Each message after it is sent out as a single wide word, left-justified, together with a one-cycle valid pulse. The consumer is always ready and never acknowledges. Bytes left after a unit are moved to the front of the buffer in the same cycle.

The framer can complete at most one unit per cycle. It therefore drops its ready output whenever another full beat might not fit in the buffer, so a run of tiny messages drains while the source waits. At the end of a packet, any complete messages are still delivered. A partial tail is discarded, and the framer returns to waiting for a header.

Top module: `lpf_framer`

## Requirements
- R1: After reset, msg_valid is low and in_ready is high.
- R2: The first HDR_BYTES (default 20) bytes of every packet are taken as the session header and never appear on the message output.
- R3: Each message starts with a two-byte length, most significant byte first, which counts only the body bytes that follow it. One message emission carries exactly that body, and msg_len equals the field value.
- R4: msg_data holds body byte 0 in bits [MSG_W-1:MSG_W-8], with later bytes following toward bit 0. Every byte position at or beyond msg_len reads zero.
- R5: A beat is taken only in a cycle where in_valid and in_ready are both high. In any other cycle, in_data, in_bytes and in_last have no effect.
- R6: A message whose length field or body is split across two or more beats is delivered intact.
- R7: At most one message is emitted per cycle. Messages always come out in stream order, including several short messages that arrive in one beat.
- R8: in_ready is low whenever the bytes held plus one full beat would exceed the buffer size, so a run of short messages throttles the input rather than losing bytes.
- R9: The beat with in_last set ends the packet. Messages already complete in the buffer are still emitted, and a partial unit is dropped. in_ready stays low until the framer is back in header state, and the next packet starts with a fresh header.
- R10: A length field greater than MAX_BODY (default 40) ends framing for that packet. Nothing more from that packet is emitted, and the next packet is framed normally.
- R11: A message with length field zero produces one emission with msg_len 0 and msg_data all zero.
- R12: in_bytes (1 to 8) gives the number of valid bytes in a beat, taken from the top of in_data. Bytes beyond that count are not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat present on in_data |
| in_data | input | BEAT_BYTES*8 | Payload beat, first byte in the top bits |
| in_bytes | input | $clog2(BEAT_BYTES+1) | Number of valid bytes in this beat |
| in_last | input | 1 | Final beat of the packet |
| in_ready | output | 1 | Framer can take a beat this cycle |
| msg_valid | output | 1 | One-cycle pulse: a message is on msg_data |
| msg_len | output | $clog2(MAX_BODY+1) | Body length of the emitted message |
| msg_data | output | MAX_BODY*8 | Message body, left-justified, zero-filled |

## Verification
The bench sweeps every body length from 0 to the maximum. It then sends packets with mixed lengths, which push length fields and bodies across beat boundaries; a framer that indexed bytes wrongly would emit shifted or merged bodies. Idle cycles with random data, random sizes and a random last flag check that nothing is taken without valid. A burst of one- and two-byte messages must force in_ready low; a framer without that throttle would overwrite buffered bytes. Three kinds of damaged packet check that stale bytes never leak into the next packet: one truncated mid-message, one truncated mid-header, and one with an oversized length.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

   typedef enum logic [1:0] {
      ST_HDR  = 2'd0,
      ST_MSG  = 2'd1,
      ST_SKIP = 2'd2
   } lpf_mode_e;

   function automatic int lpf_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lpf_byte_store.sv
module lpf_byte_store #(
   parameter  int BEAT_BYTES = 8,
   parameter  int BUF_BYTES  = 49,
   localparam int CNT_W      = $clog2(BUF_BYTES + 1),
   localparam int NB_W       = $clog2(BEAT_BYTES + 1),
   localparam int BI_W       = $clog2(BEAT_BYTES),
   localparam int BF_W       = $clog2(BUF_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [CNT_W-1:0]        consume,
   input  logic                    app_en,
   input  logic [BEAT_BYTES*8-1:0] app_data,
   input  logic [NB_W-1:0]         app_bytes,
   input  logic                    flush,
   output logic [BUF_BYTES*8-1:0]  buf_flat,
   output logic [CNT_W-1:0]        cnt_q,
   output logic [CNT_W-1:0]        peek_cnt,
   output logic [15:0]             peek_head
);

   logic [7:0]       mem_q  [BUF_BYTES];
   logic [7:0]       mem_n  [BUF_BYTES];
   logic [7:0]       beat_b [BEAT_BYTES];
   logic [CNT_W-1:0] base;

   for (genvar k = 0; k < BEAT_BYTES; k++) begin : g_beat
      assign beat_b[k] = app_data[BEAT_BYTES*8-1-8*k -: 8];
   end

   for (genvar i = 0; i < BUF_BYTES; i++) begin : g_flat
      assign buf_flat[i*8 +: 8] = mem_q[i];
   end

   // shift out the consumed unit, then place the new beat behind what remains
   always_comb begin
      int src;
      int off;
      base = cnt_q - consume;
      for (int i = 0; i < BUF_BYTES; i++) begin
         src = i + int'(consume);
         mem_n[i] = (src < BUF_BYTES) ? mem_q[BF_W'(src)] : 8'h00;
         off = i - int'(base);
         if (app_en && off >= 0 && off < int'(app_bytes)) begin
            mem_n[i] = beat_b[BI_W'(off)];
         end
      end
      peek_cnt  = base + (app_en ? CNT_W'(app_bytes) : '0);
      peek_head = {mem_n[0], mem_n[1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < BUF_BYTES; i++) mem_q[i] <= 8'h00;
      end else begin
         cnt_q <= flush ? '0 : peek_cnt;
         for (int i = 0; i < BUF_BYTES; i++) mem_q[i] <= mem_n[i];
      end
   end

endmodule

// File: rtl/lpf_unit_ctrl.sv
module lpf_unit_ctrl
   import lpf_pkg::*;
#(
   parameter  int BEAT_BYTES = 8,
   parameter  int BUF_BYTES  = 49,
   parameter  int HDR_BYTES  = 20,
   parameter  int MAX_BODY   = 40,
   localparam int CNT_W      = $clog2(BUF_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_last,
   input  logic [CNT_W-1:0] cnt_q,
   input  logic [CNT_W-1:0] peek_cnt,
   input  logic [15:0]      peek_head,
   output logic             in_ready,
   output logic             app_en,
   output logic [CNT_W-1:0] consume,
   output logic             flush,
   output logic             emit_en,
   output logic [CNT_W-1:0] body_len,
   output lpf_mode_e        mode_q,
   output logic             closing_q
);

   localparam logic [CNT_W-1:0] HDR_LEN = CNT_W'(HDR_BYTES);
   localparam logic [CNT_W-1:0] ROOM    = CNT_W'(BUF_BYTES - BEAT_BYTES);

   lpf_mode_e        mode_n;
   logic [CNT_W-1:0] cur_len_q, cur_len_n;
   logic             len_ok_q, len_ok_n;
   logic             closing_n;
   logic             unit_ready, accept, go_hdr;

   always_comb begin
      unit_ready = len_ok_q && (mode_q != ST_SKIP) && (cnt_q >= cur_len_q);
      in_ready   = (mode_q == ST_SKIP) || (!closing_q && (cnt_q <= ROOM));
      accept     = in_valid && in_ready;
      app_en     = accept && (mode_q != ST_SKIP);
      consume    = unit_ready ? cur_len_q : '0;
      emit_en    = unit_ready && (mode_q == ST_MSG);
      body_len   = cur_len_q - CNT_W'(2);
   end

   always_comb begin
      mode_n    = mode_q;
      cur_len_n = cur_len_q;
      len_ok_n  = len_ok_q;
      closing_n = closing_q | (accept & in_last);
      flush     = 1'b0;
      go_hdr    = ((mode_q == ST_SKIP) && accept && in_last) ||
                  (closing_q && !unit_ready);
      if (go_hdr) begin
         mode_n = ST_HDR; cur_len_n = HDR_LEN; len_ok_n = 1'b1;
         closing_n = 1'b0; flush = 1'b1;
      end else if ((mode_q != ST_SKIP) && (unit_ready || !len_ok_q)) begin
         // length register reloads from the bytes that follow the unit just taken
         mode_n   = ST_MSG;
         len_ok_n = 1'b0;
         if (peek_cnt >= CNT_W'(2)) begin
            if (peek_head > 16'(MAX_BODY)) begin
               flush = 1'b1;
               if (closing_n) begin
                  mode_n = ST_HDR; cur_len_n = HDR_LEN; len_ok_n = 1'b1;
                  closing_n = 1'b0;
               end else begin
                  mode_n = ST_SKIP;
               end
            end else begin
               cur_len_n = CNT_W'(peek_head) + CNT_W'(2);
               len_ok_n  = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= ST_HDR;
         cur_len_q <= HDR_LEN;
         len_ok_q  <= 1'b1;
         closing_q <= 1'b0;
      end else begin
         mode_q    <= mode_n;
         cur_len_q <= cur_len_n;
         len_ok_q  <= len_ok_n;
         closing_q <= closing_n;
      end
   end

endmodule

// File: rtl/lpf_emit_reg.sv
module lpf_emit_reg #(
   parameter  int BUF_BYTES = 49,
   parameter  int MAX_BODY  = 40,
   localparam int CNT_W     = $clog2(BUF_BYTES + 1),
   localparam int MLEN_W    = $clog2(MAX_BODY + 1),
   localparam int MSG_W     = MAX_BODY * 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   emit_en,
   input  logic [CNT_W-1:0]       body_len,
   input  logic [BUF_BYTES*8-1:0] buf_flat,
   output logic                   msg_valid,
   output logic [MLEN_W-1:0]      msg_len,
   output logic [MSG_W-1:0]       msg_data
);

   logic [MSG_W-1:0] body_n;

   // body starts after the two length bytes; positions past the length are zero
   for (genvar j = 0; j < MAX_BODY; j++) begin : g_body
      assign body_n[MSG_W-1-8*j -: 8] =
         (CNT_W'(j) < body_len) ? buf_flat[(j+2)*8 +: 8] : 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg_len   <= '0;
         msg_data  <= '0;
      end else begin
         msg_valid <= emit_en;
         if (emit_en) begin
            msg_len  <= MLEN_W'(body_len);
            msg_data <= body_n;
         end
      end
   end

endmodule

// File: rtl/lpf_framer.sv
module lpf_framer
   import lpf_pkg::*;
#(
   parameter  int BEAT_BYTES = 8,
   parameter  int HDR_BYTES  = 20,
   parameter  int MAX_BODY   = 40,
   localparam int DATA_W     = BEAT_BYTES * 8,
   localparam int NB_W       = $clog2(BEAT_BYTES + 1),
   localparam int MLEN_W     = $clog2(MAX_BODY + 1),
   localparam int MSG_W      = MAX_BODY * 8,
   localparam int BUF_BYTES  = lpf_max(MAX_BODY + 2, HDR_BYTES) + BEAT_BYTES - 1,
   localparam int CNT_W      = $clog2(BUF_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [NB_W-1:0]   in_bytes,
   input  logic              in_last,
   output logic              in_ready,
   output logic              msg_valid,
   output logic [MLEN_W-1:0] msg_len,
   output logic [MSG_W-1:0]  msg_data
);

   if (BEAT_BYTES < 2) begin : g_bad_beat
      $error("lpf_framer: BEAT_BYTES must be at least 2");
   end
   if (HDR_BYTES < 1) begin : g_bad_hdr
      $error("lpf_framer: HDR_BYTES must be at least 1");
   end
   if (MAX_BODY < 1 || MAX_BODY > 65535) begin : g_bad_body
      $error("lpf_framer: MAX_BODY must lie in 1..65535");
   end

   logic [CNT_W-1:0]       consume, store_cnt, peek_cnt, body_len;
   logic [15:0]            peek_head;
   logic [BUF_BYTES*8-1:0] buf_flat;
   logic                   app_en, flush, emit_en, closing;
   lpf_mode_e              mode;

   lpf_byte_store #(.BEAT_BYTES(BEAT_BYTES), .BUF_BYTES(BUF_BYTES)) u_store (
      .clk(clk), .rst_n(rst_n), .consume(consume), .app_en(app_en),
      .app_data(in_data), .app_bytes(in_bytes), .flush(flush),
      .buf_flat(buf_flat), .cnt_q(store_cnt), .peek_cnt(peek_cnt),
      .peek_head(peek_head)
   );

   lpf_unit_ctrl #(
      .BEAT_BYTES(BEAT_BYTES), .BUF_BYTES(BUF_BYTES),
      .HDR_BYTES(HDR_BYTES), .MAX_BODY(MAX_BODY)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
      .cnt_q(store_cnt), .peek_cnt(peek_cnt), .peek_head(peek_head),
      .in_ready(in_ready), .app_en(app_en), .consume(consume),
      .flush(flush), .emit_en(emit_en), .body_len(body_len),
      .mode_q(mode), .closing_q(closing)
   );

   lpf_emit_reg #(.BUF_BYTES(BUF_BYTES), .MAX_BODY(MAX_BODY)) u_emit (
      .clk(clk), .rst_n(rst_n), .emit_en(emit_en), .body_len(body_len),
      .buf_flat(buf_flat), .msg_valid(msg_valid), .msg_len(msg_len),
      .msg_data(msg_data)
   );

endmodule

// File: rtl/lpf_framer_chk.sv
module lpf_framer_chk
   import lpf_pkg::*;
#(
   parameter  int BEAT_BYTES = 8,
   parameter  int MAX_BODY   = 40,
   parameter  int BUF_BYTES  = 49,
   localparam int CNT_W      = $clog2(BUF_BYTES + 1),
   localparam int MLEN_W     = $clog2(MAX_BODY + 1),
   localparam int MSG_W      = MAX_BODY * 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              msg_valid,
   input logic [MLEN_W-1:0] msg_len,
   input logic [MSG_W-1:0]  msg_data,
   input logic [CNT_W-1:0]  store_cnt,
   input lpf_mode_e         mode,
   input logic              closing
);

   logic tail_bad;

   always_comb begin
      tail_bad = 1'b0;
      for (int j = 0; j < MAX_BODY; j++) begin
         if (j >= int'(msg_len) && msg_data[MSG_W-1-8*j -: 8] != 8'h00) tail_bad = 1'b1;
      end
   end

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      int'(store_cnt) <= BUF_BYTES);

   p_ready_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && mode != ST_SKIP) |-> (int'(store_cnt) + BEAT_BYTES <= BUF_BYTES));

   p_close_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      closing |-> !in_ready);

   p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> (int'(msg_len) <= MAX_BODY));

   p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> !tail_bad);

   p_hdr_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == ST_HDR) |=> !msg_valid);

   p_skip_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == ST_SKIP) |=> !msg_valid);

endmodule

bind lpf_framer lpf_framer_chk #(
   .BEAT_BYTES(BEAT_BYTES), .MAX_BODY(MAX_BODY), .BUF_BYTES(BUF_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .msg_valid(msg_valid),
   .msg_len(msg_len), .msg_data(msg_data), .store_cnt(store_cnt),
   .mode(mode), .closing(closing)
);

// File: tb/test_lpf_framer.sv
`timescale 1ns/1ps
module test_lpf_framer;

   localparam int BEAT   = 8;
   localparam int HDR    = 20;
   localparam int MAXB   = 40;
   localparam int DW     = BEAT * 8;
   localparam int NB_W   = $clog2(BEAT + 1);
   localparam int MLEN_W = $clog2(MAXB + 1);
   localparam int MSG_W  = MAXB * 8;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              in_valid;
   logic [DW-1:0]     in_data;
   logic [NB_W-1:0]   in_bytes;
   logic              in_last;
   logic              in_ready;
   logic              msg_valid;
   logic [MLEN_W-1:0] msg_len;
   logic [MSG_W-1:0]  msg_data;

   always #2.5 clk = ~clk;

   lpf_framer #(.BEAT_BYTES(BEAT), .HDR_BYTES(HDR), .MAX_BODY(MAXB)) i_lpf_framer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_bytes(in_bytes), .in_last(in_last), .in_ready(in_ready),
      .msg_valid(msg_valid), .msg_len(msg_len), .msg_data(msg_data)
   );

   typedef struct {
      int               len;
      logic [MSG_W-1:0] data;
      string            tag;
   } exp_t;

   exp_t       exp_q[$];
   exp_t       cur_e;
   logic [7:0] tx[$];
   int         n_chk = 0;
   int         n_fail = 0;
   int         seed_ctr = 0;
   int         ready_low = 0;
   bit         done = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [MSG_W-1:0] act, input logic [MSG_W-1:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // output monitor, sampled half a period after the edge
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n === 1'b1 && msg_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2", "unexpected message", MSG_W'(msg_len), '0);
            end else begin
               cur_e = exp_q.pop_front();
               check(int'(msg_len) == cur_e.len, cur_e.tag, "length (R3)",
                     MSG_W'(msg_len), MSG_W'(cur_e.len));
               check(msg_data == cur_e.data, cur_e.tag, "body (R4)",
                     msg_data, cur_e.data);
            end
         end
      end
   end

   task automatic add_hdr();
      for (int i = 0; i < HDR; i++) tx.push_back(8'(8'h5A ^ (i * 3)));
   endtask

   task automatic add_len(input int len);
      tx.push_back(8'(len >> 8));
      tx.push_back(8'(len));
   endtask

   task automatic add_msg(input int len, input string tag, input bit keep);
      logic [MSG_W-1:0] d;
      logic [7:0]       b;
      d = '0;
      seed_ctr++;
      add_len(len);
      for (int j = 0; j < len; j++) begin
         b = 8'(seed_ctr * 29 + j * 7 + 3);
         tx.push_back(b);
         if (j < MAXB) d[MSG_W-1-8*j -: 8] = b;
      end
      if (keep) exp_q.push_back('{len, d, tag});
   endtask

   task automatic send_pkt(input bit gaps);
      int            pos;
      int            nb;
      logic [DW-1:0] w;
      bit            acc;
      pos = 0;
      while (pos < tx.size()) begin
         nb = (tx.size() - pos >= BEAT) ? BEAT : tx.size() - pos;
         if (gaps) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = {$urandom, $urandom};
            in_bytes = NB_W'($urandom);
            in_last  = 1'($urandom);
            @(posedge clk);
         end
         @(negedge clk);
         w = {BEAT{8'hAA}};
         for (int k = 0; k < nb; k++) w[DW-1-8*k -: 8] = tx[pos + k];
         in_valid = 1'b1;
         in_data  = w;
         in_bytes = NB_W'(nb);
         in_last  = (pos + nb == tx.size());
         #1;
         acc = in_ready;
         if (!acc) ready_low++;
         @(posedge clk);
         if (acc) pos += nb;
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      in_data  = {$urandom, $urandom};
      tx.delete();
   endtask

   task automatic drain(input string req);
      repeat (80) @(negedge clk);
      check(exp_q.size() == 0, req, "messages missing", MSG_W'(exp_q.size()), '0);
   endtask

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_data  = '0;
      in_bytes = '0;
      in_last  = 1'b0;
      repeat (3) @(negedge clk);
      check(msg_valid == 1'b0, "R1", "msg_valid in reset", MSG_W'(msg_valid), '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(msg_valid == 1'b0, "R1", "msg_valid after reset", MSG_W'(msg_valid), '0);
      check(in_ready == 1'b1, "R1", "in_ready after reset", MSG_W'(in_ready), 1);

      // every body length, one message per packet; R11 zero length, R12 partial last beat
      for (int len = 0; len <= MAXB; len++) begin
         add_hdr();
         add_msg(len, (len == 0) ? "R11" : (((HDR + 2 + len) % BEAT) != 0) ? "R12" : "R3", 1'b1);
         send_pkt(1'b0);
         drain("R2");
      end

      // mixed lengths straddling beats (R6)
      for (int s = 0; s < BEAT; s++) begin
         add_hdr();
         add_msg(s + 3, "R6", 1'b1);
         add_msg(13, "R6", 1'b1);
         add_msg(MAXB - s, "R6", 1'b1);
         add_msg(1, "R6", 1'b1);
         add_msg(7 + s, "R6", 1'b1);
         send_pkt(1'b0);
         drain("R6");
      end

      // idle cycles with random contents between beats (R5)
      for (int s = 0; s < 4; s++) begin
         add_hdr();
         add_msg(5 + s, "R5", 1'b1);
         add_msg(22 - s, "R5", 1'b1);
         add_msg(s, "R5", 1'b1);
         send_pkt(1'b1);
         drain("R5");
      end

      // burst of tiny messages: in-order single emissions (R7) and throttling (R8)
      ready_low = 0;
      add_hdr();
      for (int m = 0; m < 40; m++) add_msg(m % 3, "R7", 1'b1);
      send_pkt(1'b0);
      drain("R7");
      check(ready_low > 0, "R8", "in_ready never dropped", MSG_W'(ready_low), 1);

      // truncated mid-message, then truncated header, then a clean packet (R9)
      add_hdr();
      add_msg(5, "R9", 1'b1);
      add_len(20);
      tx.push_back(8'h11); tx.push_back(8'h22); tx.push_back(8'h33);
      send_pkt(1'b0);
      drain("R9");
      for (int i = 0; i < 10; i++) tx.push_back(8'(i + 1));
      send_pkt(1'b0);
      drain("R9");
      add_hdr();
      add_msg(9, "R9", 1'b1);
      add_msg(2, "R9", 1'b1);
      send_pkt(1'b0);
      drain("R9");

      // oversized length field stops the packet, next packet recovers (R10)
      add_hdr();
      add_msg(4, "R10", 1'b1);
      add_len(200);
      for (int i = 0; i < 10; i++) tx.push_back(8'hC3);
      add_msg(6, "R10", 1'b0);
      send_pkt(1'b0);
      drain("R10");
      add_hdr();
      add_msg(11, "R10", 1'b1);
      send_pkt(1'b0);
      drain("R10");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual running expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule